// File: doc/BRIEF.md
# SPI Command Slave with Status Echo

This block is the serial front end of a register-mapped controller. An SPI master opens a transaction by pulling chip select low. The first byte it sends is a command. While that byte comes in, the block sends back the status byte that it captured at the falling chip-select edge. The block decodes the command into an operation and a register address. It then takes the data bytes that follow. For a write, it assembles them into a register-wide word and issues a single write strobe. For a read, it serializes the register word that the register file presents.

How bytes map onto the register word depends on where the register sits. Registers in bank 0, and bank-1 registers above address `MSB_LAST_ADDR`, carry their lowest byte first. Bank-1 registers at or below that address carry their highest byte first. Within every byte, bits travel MSB first. The register file supplies three things: the bank selection, the byte count of the addressed register, and the read word. The block samples all three one clock after it issues the command strobe.

The SPI pins are oversampled with the system clock through synchronizers. The command and write outputs are single-cycle valid pulses with no ready. An SPI master cannot be stalled, so the consumer must take each pulse in the cycle it appears. Raising chip select at any point ends the transaction and discards any partial byte.

Top module: `spi_cmd_slave`

## Requirements
- R1: While chip select is high, `spi_miso` is 0 and neither `cmd_valid` nor `wr_valid` pulses.
- R2: The value of `status_in` at the falling chip-select edge goes out on `spi_miso` MSB first during the command byte. Bit 7 appears before the first rising SCK edge.
- R3: SPI mode 0 applies. MOSI is sampled on rising SCK edges, and `spi_miso` changes only after falling SCK edges (or at the chip-select fall), never while SCK is high.
- R4: After the eighth rising edge, `cmd_valid` pulses for one cycle. With it come `cmd_code` (the whole byte) and `cmd_addr` (command bits 4:0). `cmd_op` is 0 for read (bits 7:5 = 000), 1 for write (bits 7:5 = 001), and 2 for any other pattern.
- R5: In bank 0, and in bank 1 above address `MSB_LAST_ADDR`, data byte j maps to byte lane j (bits 8j+7..8j) of the register word.
- R6: In bank 1 at or below address `MSB_LAST_ADDR`, data byte j maps to lane `len-1-j`, where len is the register byte count.
- R7: For a write, `wr_valid` pulses exactly once, after the len-th data byte. `wr_data` then holds the assembled word, and lanes at or above len are 0. Data bytes beyond len are ignored. A `reg_len` of 0 or above `DATA_BYTES` counts as `DATA_BYTES`.
- R8: For a read, data bytes from the sampled `rd_data` go out MSB first in the order of R5/R6. Bytes beyond len are sent as 0x00.
- R9: Raising chip select before a byte completes discards it. An unfinished command gives no `cmd_valid`, and an unfinished write gives no `wr_valid`. The next command is accepted only after a new falling chip-select edge.
- R10: Commands other than read and write never raise `wr_valid`, and their data bytes are answered with 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| status_in | input | 8 | Status byte echoed during the command byte |
| bank_sel | input | 1 | Register bank in use (0 or 1) |
| reg_len | input | $clog2(DATA_BYTES+1) | Byte count of the addressed register |
| rd_data | input | 8*DATA_BYTES | Read word of the addressed register |
| cmd_valid | output | 1 | One-cycle pulse: command byte decoded |
| cmd_op | output | 2 | 0 read, 1 write, 2 other |
| cmd_code | output | 8 | Raw command byte |
| cmd_addr | output | 5 | Register address from the command |
| wr_valid | output | 1 | One-cycle pulse: write word complete |
| wr_data | output | 8*DATA_BYTES | Assembled write word |

## Verification
The bench uses the defaults: `DATA_BYTES` = 4, `MSB_LAST_ADDR` = 8 and two synchronizer stages. It models a register file whose byte count runs 1 to 4 with the address, which makes every length and both byte-order rules reachable. It reads and writes each of the 32 addresses in both banks, and every transaction carries one surplus data byte. That covers the lane mapping, truncation and zero fill at every length. Aborts inside the command and inside the data, along with a non-read/write command, cover the discard paths.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_OTHER = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic [CMD_W-1:0] code);
    case (code[7:5])
      3'b000:  return OP_READ;
      3'b001:  return OP_WRITE;
      default: return OP_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_shift_in.sv
module spi_shift_in #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              bit_in,
  output logic [2:0]        bit_cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out
);
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
    end else if (sample) begin
      sh      <= {sh[BYTE_W-3:0], bit_in};
      bit_cnt <= bit_cnt + 3'd1;
    end
  end

  assign byte_done = sample && !clear && (bit_cnt == 3'd7);
  assign byte_out  = {sh, bit_in};
endmodule

// File: rtl/spi_lane_sel.sv
module spi_lane_sel #(
  parameter int DATA_BYTES = 4,
  localparam int CNT_W  = $clog2(DATA_BYTES + 1),
  localparam int LANE_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic [CNT_W-1:0]  idx,
  input  logic [CNT_W-1:0]  len,
  input  logic              msb_first,
  output logic [LANE_W-1:0] lane
);
  logic [CNT_W-1:0] rev;

  always_comb begin
    rev  = len - CNT_W'(1) - idx;
    lane = msb_first ? rev[LANE_W-1:0] : idx[LANE_W-1:0];
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int DATA_BYTES    = 4,
  parameter int MSB_LAST_ADDR = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W  = $clog2(DATA_BYTES + 1),
  localparam int LANE_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int WORD_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [7:0]        status_in,
  input  logic              bank_sel,
  input  logic [CNT_W-1:0]  reg_len,
  input  logic [WORD_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_code,
  output logic [4:0]        cmd_addr,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(DATA_BYTES);

  logic sck_s, csn_s, mosi_s;
  logic sck_p, csn_p;
  logic sck_rise, sck_fall, csn_fall;

  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(spi_sck), .q(sck_s));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csn_sync (
    .clk(clk), .rst_n(rst_n), .din(spi_csn), .q(csn_s));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi_sync (
    .clk(clk), .rst_n(rst_n), .din(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0;
      csn_p <= 1'b1;
    end else begin
      sck_p <= sck_s;
      csn_p <= csn_s;
    end
  end

  assign sck_rise = sck_s && !sck_p;
  assign sck_fall = !sck_s && sck_p;
  assign csn_fall = !csn_s && csn_p;

  // transaction state
  logic              active, cmd_done, load_pend;
  op_e               op_q;
  logic [4:0]        addr_q;
  logic [CNT_W-1:0]  dcnt, len_q;
  logic              msb_q;
  logic [WORD_W-1:0] rd_q, wr_acc, acc_next;
  logic [6:0]        tx_sh;
  logic              miso_q;

  logic [2:0] bit_cnt;
  logic       byte_done;
  logic [7:0] rx_byte;

  spi_shift_in #(.BYTE_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .clear(csn_s || csn_fall || !active),
    .sample(active && sck_rise),
    .bit_in(mosi_s),
    .bit_cnt(bit_cnt),
    .byte_done(byte_done),
    .byte_out(rx_byte));

  logic [LANE_W-1:0] lane;

  spi_lane_sel #(.DATA_BYTES(DATA_BYTES)) u_lane (
    .idx(dcnt), .len(len_q), .msb_first(msb_q), .lane(lane));

  logic       in_range, last_byte;
  logic [7:0] next_tx;
  logic [CNT_W-1:0] eff_len;

  always_comb begin
    in_range  = dcnt < len_q;
    last_byte = dcnt == (len_q - CNT_W'(1));
    acc_next  = wr_acc;
    acc_next[8*lane +: 8] = rx_byte;
    next_tx   = (op_q == OP_READ && in_range) ? rd_q[8*lane +: 8] : 8'h00;
    eff_len   = (reg_len == '0 || reg_len > MAX_LEN) ? MAX_LEN : reg_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cmd_done  <= 1'b0;
      load_pend <= 1'b0;
      op_q      <= OP_OTHER;
      addr_q    <= '0;
      dcnt      <= '0;
      len_q     <= MAX_LEN;
      msb_q     <= 1'b0;
      rd_q      <= '0;
      wr_acc    <= '0;
      tx_sh     <= '0;
      miso_q    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      load_pend <= 1'b0;
      if (csn_s) begin
        active   <= 1'b0;
        cmd_done <= 1'b0;
        miso_q   <= 1'b0;
      end else if (csn_fall) begin
        active   <= 1'b1;
        cmd_done <= 1'b0;
        dcnt     <= '0;
        miso_q   <= status_in[7];
        tx_sh    <= status_in[6:0];
      end else if (active) begin
        if (byte_done) begin
          if (!cmd_done) begin
            cmd_done  <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_code  <= rx_byte;
            op_q      <= decode_op(rx_byte);
            addr_q    <= rx_byte[4:0];
            load_pend <= 1'b1;
            dcnt      <= '0;
            wr_acc    <= '0;
          end else begin
            if (in_range && op_q == OP_WRITE) begin
              wr_acc <= acc_next;
              if (last_byte) begin
                wr_valid <= 1'b1;
                wr_data  <= acc_next;
              end
            end
            if (dcnt != MAX_LEN) dcnt <= dcnt + CNT_W'(1);
          end
        end
        if (load_pend) begin
          len_q <= eff_len;
          msb_q <= bank_sel && (int'(addr_q) <= MSB_LAST_ADDR);
          rd_q  <= rd_data;
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0 && cmd_done) begin
            miso_q <= next_tx[7];
            tx_sh  <= next_tx[6:0];
          end else begin
            miso_q <= tx_sh[6];
            tx_sh  <= {tx_sh[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign spi_miso = miso_q;
  assign cmd_op   = op_q;
  assign cmd_addr = addr_q;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic       csn_fall,
  input logic       sck_rise,
  input logic       active,
  input logic       cmd_done,
  input logic       miso,
  input logic       status7,
  input logic       cmd_valid,
  input logic       wr_valid,
  input logic [1:0] op_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> (!cmd_valid && !wr_valid && !miso));

  assert_echo_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_fall |=> (miso == $past(status7)));

  assert_miso_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && active) |-> $stable(miso));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, wr_valid}));

  assert_write_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> cmd_done);

  assert_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (op_q == 2'd1));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .csn_fall(csn_fall),
  .sck_rise(sck_rise), .active(active), .cmd_done(cmd_done),
  .miso(spi_miso), .status7(status_in[7]), .cmd_valid(cmd_valid),
  .wr_valid(wr_valid), .op_q(cmd_op));

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb_top;
  localparam int NB   = 4;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] status = 8'h00;
  logic bank = 1'b0;
  logic [2:0] rlen;
  logic [31:0] rdat;
  logic cmd_valid, wr_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_code;
  logic [4:0] cmd_addr;
  logic [31:0] wr_data;

  always #10 clk = ~clk;

  function automatic logic [31:0] regval(input logic [4:0] a);
    return 32'h44332211 + {4{3'b000, a}};
  endfunction
  function automatic logic [2:0] lenof(input logic [4:0] a);
    return 3'(a % 4) + 3'd1;
  endfunction

  assign rdat = regval(cmd_addr);
  assign rlen = lenof(cmd_addr);

  spi_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .status_in(status), .bank_sel(bank), .reg_len(rlen),
    .rd_data(rdat), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data));

  int total = 0, bad = 0;
  int cmd_cnt = 0, wr_cnt = 0, glitch = 0;
  logic [1:0] last_op;
  logic [4:0] last_addr;
  logic [7:0] last_code;
  logic [31:0] last_wr;
  logic [7:0] tx_buf [0:7];
  logic [7:0] rx_buf [0:7];
  bit done = 0;

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt++; last_op = cmd_op; last_addr = cmd_addr; last_code = cmd_code;
    end
    if (wr_valid) begin
      wr_cnt++; last_wr = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // shifts nbits from tx_buf, then raises chip select
  task automatic spi_run(input int nbits);
    csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic cap;
      mosi = tx_buf[i/8][7 - i%8];
      repeat (HALF) @(negedge clk);
      cap = miso;
      rx_buf[i/8][7 - i%8] = cap;
      sck = 1'b1;
      repeat (HALF/2) @(negedge clk);
      if (miso !== cap) glitch++;
      repeat (HALF - HALF/2) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset / idle state
    chk(miso == 1'b0 && !cmd_valid && !wr_valid, "R1 idle outputs",
        {29'd0, miso, cmd_valid, wr_valid}, 32'd0);

    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 32; a++) begin
        int len, c0, w0;
        bit msbf;
        logic [31:0] exp;
        bank = b[0];
        len  = a % 4 + 1;
        msbf = (b == 1) && (a <= 8);
        // read transaction, one surplus data byte
        status = 8'(a * 7 + b * 3 + 8'h81);
        tx_buf[0] = {3'b000, 5'(a)};
        for (int j = 1; j < 8; j++) tx_buf[j] = 8'hFF;
        c0 = cmd_cnt; w0 = wr_cnt;
        spi_run(8 * (len + 2));
        chk(rx_buf[0] == status, "R2 status echo", {24'd0, rx_buf[0]}, {24'd0, status});
        chk(cmd_cnt == c0 + 1 && last_addr == 5'(a) && last_op == 2'd0 && last_code == tx_buf[0],
            "R4 read decode", {22'd0, last_op, last_addr, 3'd0}, {22'd0, 2'd0, 5'(a), 3'd0});
        chk(wr_cnt == w0, "R10 read gives no write", 32'(wr_cnt), 32'(w0));
        for (int j = 0; j <= len; j++) begin
          logic [7:0] e;
          int ln;
          ln = msbf ? (len - 1 - j) : j;
          e  = (j < len) ? regval(5'(a))[8*ln +: 8] : 8'h00;
          chk(rx_buf[j+1] == e, msbf ? "R6/R8 read byte" : "R5/R8 read byte",
              {24'd0, rx_buf[j+1]}, {24'd0, e});
        end
        // write transaction, one surplus data byte
        tx_buf[0] = {3'b001, 5'(a)};
        for (int j = 0; j < 7; j++) tx_buf[j+1] = 8'(8'h5C ^ (j * 8'h11) ^ a);
        exp = '0;
        for (int j = 0; j < len; j++) begin
          int ln;
          ln = msbf ? (len - 1 - j) : j;
          exp[8*ln +: 8] = tx_buf[j+1];
        end
        c0 = cmd_cnt; w0 = wr_cnt;
        spi_run(8 * (len + 2));
        chk(cmd_cnt == c0 + 1 && last_op == 2'd1 && last_addr == 5'(a), "R4 write decode",
            {22'd0, last_op, last_addr, 3'd0}, {22'd0, 2'd1, 5'(a), 3'd0});
        chk(wr_cnt == w0 + 1, "R7 one write strobe", 32'(wr_cnt - w0), 32'd1);
        chk(last_wr == exp, msbf ? "R6/R7 write word" : "R5/R7 write word", last_wr, exp);
      end
    end
    chk(glitch == 0, "R3 miso steady while sck high", 32'(glitch), 32'd0);

    // R10: other command, no write, zero data
    bank = 1'b0;
    tx_buf[0] = 8'hE5; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34;
    begin
      int c0, w0;
      c0 = cmd_cnt; w0 = wr_cnt;
      spi_run(24);
      chk(cmd_cnt == c0 + 1 && last_op == 2'd2 && last_addr == 5'd5, "R4 other decode",
          {30'd0, last_op}, 32'd2);
      chk(wr_cnt == w0, "R10 other no write", 32'(wr_cnt - w0), 32'd0);
      chk(rx_buf[1] == 8'h00 && rx_buf[2] == 8'h00, "R10 other data zero",
          {16'd0, rx_buf[1], rx_buf[2]}, 32'd0);

      // R9: abort within command byte
      tx_buf[0] = 8'h23;
      c0 = cmd_cnt;
      spi_run(5);
      chk(cmd_cnt == c0, "R9 partial command dropped", 32'(cmd_cnt - c0), 32'd0);

      // R9: abort within write data (addr 3, len 4)
      tx_buf[0] = 8'h23; tx_buf[1] = 8'hAA; tx_buf[2] = 8'hBB; tx_buf[3] = 8'hCC;
      w0 = wr_cnt;
      spi_run(8 + 16 + 3);
      chk(wr_cnt == w0, "R9 partial write dropped", 32'(wr_cnt - w0), 32'd0);

      // R9: a fresh transaction after the abort works
      tx_buf[0] = 8'h21; tx_buf[1] = 8'h9D; tx_buf[2] = 8'h6E;
      w0 = wr_cnt;
      spi_run(24);
      chk(wr_cnt == w0 + 1 && last_wr == 32'h0000_6E9D, "R9 recovery write", last_wr, 32'h0000_6E9D);
    end

    repeat (4) @(negedge clk);
    chk(miso == 1'b0, "R1 idle miso after traffic", {31'd0, miso}, 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule